// File: doc/BRIEF.md
# Debug Control Register Block with Authentication Gate

This block holds the control and status registers that an external debugger reaches over a simple register bus. The bus has an address, write data, a write strobe and combinational read data. Through these registers the debugger turns the block on and off. It also raises halt, resume and hart-reset requests toward one selected hart, raises a system-wide reset request, and picks a hart through a select field. Only the implemented low bits of that select field are kept.

When the block is built with authentication required, it starts unauthenticated. In that state every control field except the activation bit ignores writes. The debugger reads a challenge word, writes back the matching response, and so unlocks the controls. A write that turns the activation bit from 0 to 1 reinitialises the whole block. It clears every request, drops any earlier authentication and latches a fresh challenge from a free-running LFSR. The response is computed from the challenge as follows: swap its two 16-bit halves, then XOR the result with the `AUTH_KEY` parameter.

Top module: `dbg_ctrl_auth`

## Requirements
- R1: After reset, the status register (address 0x05) reads version 2 in bits [3:0], implicit-breakpoint 1 in bit 7 and authenticated (bit 6) equal to the inverse of `AUTH_REQ`. The control register (address 0x04) reads 0.
- R2: Every write to the control register updates the activation bit (bit 0) from the written value, whether the block is authenticated or not.
- R3: While unauthenticated, a control write leaves system reset (bit 1), hart reset (bit 2), resume (bit 4), halt (bit 5) and hart select (bits [17:8]) unchanged.
- R4: A control write that takes the activation bit from 0 to 1 reinitialises the block. All request fields and hart select go to 0, authenticated goes to the inverse of `AUTH_REQ`, and a new challenge is latched.
- R5: While active and authenticated, a control write with bit 0 set loads halt, resume, hart reset, system reset and hart select from the written data.
- R6: Only the low `SEL_BITS` bits of hart select are stored. The upper bits of the 10-bit field read back as 0.
- R7: While the activation bit is 0, every control field other than the activation bit reads as 0, and all request outputs are 0.
- R8: While unauthenticated, a write to the authentication register (address 0x06) sets authenticated when the data equals the expected response, and leaves it clear otherwise.
- R9: The halt, resume and hart-reset outputs are asserted only on the bit of the hart given by hart select. They are all 0 when hart select is `NUM_HARTS` or above. `sys_reset_o` follows the system reset field while active.
- R10: The authentication register reads the current challenge, and each reinitialisation replaces it with a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| halt_req_o | output | NUM_HARTS | Halt request per hart |
| resume_req_o | output | NUM_HARTS | Resume request per hart |
| hart_reset_o | output | NUM_HARTS | Reset request per hart |
| sys_reset_o | output | 1 | System reset request |

## Verification
The bench writes request fields both before and after authentication. A gate that leaked would change the control read-back or pulse a halt output. It toggles activation off and on after authenticating. A block that skipped reinitialisation would stay authenticated, keep its old challenge, or still show its old requests. It writes every bit of the 10-bit select field and selects a hart that is not implemented. Poor masking would echo the upper bits or decode a phantom hart. It also replays a stale response against a new challenge, which a compare against the wrong word would accept.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned HSEL_FIELD_W = 10;

    // register offsets
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_STATUS = 8'h05;
    localparam logic [7:0] OFS_AUTH   = 8'h06;

    // control register bit positions
    localparam int unsigned CTL_ACTIVE = 0;
    localparam int unsigned CTL_SYSRST = 1;
    localparam int unsigned CTL_HRST   = 2;
    localparam int unsigned CTL_RESUME = 4;
    localparam int unsigned CTL_HALT   = 5;
    localparam int unsigned CTL_HSEL   = 8;

    // status register bit positions
    localparam int unsigned ST_AUTH    = 6;
    localparam int unsigned ST_IMPBRK  = 7;
    localparam logic [3:0]  ST_VERSION = 4'd2;

    function automatic logic [DATA_W-1:0] auth_response(
        input logic [DATA_W-1:0] chal,
        input logic [DATA_W-1:0] key
    );
        return {chal[15:0], chal[31:16]} ^ key;
    endfunction
endpackage

// File: rtl/dbg_chal_lfsr.sv
module dbg_chal_lfsr #(
    parameter int unsigned       W    = 32,
    parameter logic [W-1:0]      SEED = 32'h1D2C_3B4A,
    parameter logic [W-1:0]      TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value_o
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[W-1:1]};
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value_o = lfsr_q;

    a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/dbg_auth_check.sv
module dbg_auth_check
    import dbg_ctrl_pkg::*;
#(
    parameter logic [DATA_W-1:0] AUTH_KEY = 32'h5A3C_96E1
) (
    input  logic [DATA_W-1:0] chal_i,
    input  logic [DATA_W-1:0] resp_i,
    output logic              match_o
);
    logic [DATA_W-1:0] expect_w;

    always_comb begin
        expect_w = auth_response(chal_i, AUTH_KEY);
        match_o  = (resp_i == expect_w);
    end
endmodule

// File: rtl/dbg_hart_req_dec.sv
module dbg_hart_req_dec #(
    parameter int unsigned NUM_HARTS = 3,
    parameter int unsigned SEL_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [SEL_BITS-1:0]  sel_i,
    input  logic                 halt_i,
    input  logic                 resume_i,
    input  logic                 hreset_i,
    output logic [NUM_HARTS-1:0] halt_o,
    output logic [NUM_HARTS-1:0] resume_o,
    output logic [NUM_HARTS-1:0] hreset_o
);
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic hit;
        assign hit         = en_i && (sel_i == SEL_BITS'(h));
        assign halt_o[h]   = hit && halt_i;
        assign resume_o[h] = hit && resume_i;
        assign hreset_o[h] = hit && hreset_i;
    end

    a_r9_halt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_o));
    a_r9_resume_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resume_o));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (halt_o == '0 && resume_o == '0 && hreset_o == '0));
endmodule

// File: rtl/dbg_ctrl_auth.sv
module dbg_ctrl_auth
    import dbg_ctrl_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       NUM_HARTS = 3,
    parameter int unsigned       SEL_BITS  = 2,
    parameter bit                AUTH_REQ  = 1'b1,
    parameter logic [DATA_W-1:0] AUTH_KEY  = 32'h5A3C_96E1,
    parameter logic [DATA_W-1:0] LFSR_SEED = 32'h1D2C_3B4A
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_we,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_HARTS-1:0] halt_req_o,
    output logic [NUM_HARTS-1:0] resume_req_o,
    output logic [NUM_HARTS-1:0] hart_reset_o,
    output logic                 sys_reset_o
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_AUTH   = ADDR_W'(OFS_AUTH);

    typedef struct packed {
        logic                active;
        logic                halt;
        logic                resume;
        logic                hreset;
        logic                sreset;
        logic [SEL_BITS-1:0] hsel;
        logic                auth;
        logic [DATA_W-1:0]   chal;
    } dbg_state_t;

    dbg_state_t        st_d, st_q;
    logic [DATA_W-1:0] lfsr_w;
    logic              resp_ok;
    logic              ctrl_wr, auth_wr;

    dbg_chal_lfsr #(.W(DATA_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_o (lfsr_w)
    );

    dbg_auth_check #(.AUTH_KEY(AUTH_KEY)) u_auth (
        .chal_i  (st_q.chal),
        .resp_i  (reg_wdata),
        .match_o (resp_ok)
    );

    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
    assign auth_wr = reg_we && (reg_addr == A_AUTH);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            if (!st_q.active && reg_wdata[CTL_ACTIVE]) begin
                st_d      = '0;
                st_d.auth = ~AUTH_REQ;
                st_d.chal = lfsr_w;
            end
            st_d.active = reg_wdata[CTL_ACTIVE];
            if (st_d.auth && st_d.active) begin
                st_d.halt   = reg_wdata[CTL_HALT];
                st_d.resume = reg_wdata[CTL_RESUME];
                st_d.hreset = reg_wdata[CTL_HRST];
                st_d.sreset = reg_wdata[CTL_SYSRST];
                st_d.hsel   = reg_wdata[CTL_HSEL +: SEL_BITS];
            end
        end
        if (auth_wr && !st_q.auth && resp_ok) st_d.auth = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.auth <= ~AUTH_REQ;
            st_q.chal <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[CTL_ACTIVE] = st_q.active;
            if (st_q.active) begin
                reg_rdata[CTL_HALT]               = st_q.halt;
                reg_rdata[CTL_RESUME]             = st_q.resume;
                reg_rdata[CTL_HRST]               = st_q.hreset;
                reg_rdata[CTL_SYSRST]             = st_q.sreset;
                reg_rdata[CTL_HSEL +: SEL_BITS]   = st_q.hsel;
            end
        end else if (reg_addr == A_STATUS) begin
            reg_rdata[3:0]       = ST_VERSION;
            reg_rdata[ST_AUTH]   = st_q.auth;
            reg_rdata[ST_IMPBRK] = 1'b1;
        end else if (reg_addr == A_AUTH) begin
            reg_rdata = st_q.chal;
        end
    end

    dbg_hart_req_dec #(.NUM_HARTS(NUM_HARTS), .SEL_BITS(SEL_BITS)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (st_q.active),
        .sel_i    (st_q.hsel),
        .halt_i   (st_q.halt),
        .resume_i (st_q.resume),
        .hreset_i (st_q.hreset),
        .halt_o   (halt_req_o),
        .resume_o (resume_req_o),
        .hreset_o (hart_reset_o)
    );

    assign sys_reset_o = st_q.active && st_q.sreset;

    a_r2_active_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> st_q.active == $past(reg_wdata[CTL_ACTIVE]));
    a_r3_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !st_q.auth && st_q.active)
        |=> ($stable(st_q.halt) && $stable(st_q.resume) && $stable(st_q.hreset)
             && $stable(st_q.sreset) && $stable(st_q.hsel)));
    a_r4_reinit_auth: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !st_q.active && reg_wdata[CTL_ACTIVE])
        |=> (st_q.auth == ~AUTH_REQ));
    a_r8_bad_response: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_wr && !resp_ok && !st_q.auth && !ctrl_wr) |=> !st_q.auth);
    a_r9_sysrst_gated: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_o |-> st_q.active);
endmodule

// File: tb/dbg_ctrl_auth_tb.sv
module dbg_ctrl_auth_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 3;
    localparam int SB = 2;
    localparam logic [31:0] KEY = 32'h5A3C_96E1;
    localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h05, A_AUTH = 8'h06;

    logic clk = 0, rst_n = 0, reg_we = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [NH-1:0] halt_req_o, resume_req_o, hart_reset_o;
    logic sys_reset_o;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_ctrl_auth u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .halt_req_o(halt_req_o),
        .resume_req_o(resume_req_o), .hart_reset_o(hart_reset_o),
        .sys_reset_o(sys_reset_o)
    );

    function automatic logic [31:0] resp_of(input logic [31:0] c);
        return {c[15:0], c[31:16]} ^ KEY;
    endfunction

    // expected control read-back for an accepted write (R5, R6)
    function automatic logic [31:0] ctrl_exp(input logic [31:0] w);
        logic [31:0] e = '0;
        e[0] = w[0];
        if (w[0]) begin
            e[1] = w[1]; e[2] = w[2]; e[4] = w[4]; e[5] = w[5];
            e[8 +: SB] = w[8 +: SB];
        end
        return e;
    endfunction

    function automatic logic [NH-1:0] hart_vec(input logic [31:0] w, input int bitpos);
        int s = int'(w[8 +: SB]);
        if (!w[0] || !w[bitpos] || s >= NH) return '0;
        return NH'(1) << s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic chk_outs(input string tag, input logic [31:0] w);
        #1;
        chk({tag, " halt"},   32'(halt_req_o),   32'(hart_vec(w, 5)));
        chk({tag, " resume"}, 32'(resume_req_o), 32'(hart_vec(w, 4)));
        chk({tag, " hrst"},   32'(hart_reset_o), 32'(hart_vec(w, 2)));
        chk({tag, " sysrst"}, 32'(sys_reset_o),  32'(w[0] && w[1]));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, c0, c1, w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;

        rd(A_STAT, v);  chk("R1 status", v, 32'h0000_0082);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        chk_outs("R7 reset", 32'h0);

        // activation while unauthenticated: fields dropped
        wr(A_CTRL, 32'h0000_0137);
        rd(A_CTRL, v);  chk("R2/R3 activate unauth", v, 32'h1);
        chk_outs("R3 unauth", 32'h1);
        wr(A_CTRL, 32'h0000_0131);
        rd(A_CTRL, v);  chk("R3 locked", v, 32'h1);

        rd(A_AUTH, c0);
        wr(A_AUTH, resp_of(c0) ^ 32'h1);
        rd(A_STAT, v);  chk("R8 wrong response", v[6], 1'b0);
        wr(A_AUTH, resp_of(c0));
        rd(A_STAT, v);  chk("R8 right response", v[6], 1'b1);

        w = 32'h0000_0221;
        wr(A_CTRL, w);
        rd(A_CTRL, v);  chk("R5 fields", v, ctrl_exp(w));
        chk_outs("R9 hart2", w);

        w = 32'h0003_FF37;
        wr(A_CTRL, w);
        rd(A_CTRL, v);  chk("R6 mask", v, 32'h0000_0337);
        chk_outs("R9 hart3 absent", w);

        for (int i = 0; i < 300; i++) begin
            w = $urandom() | 32'h1;
            wr(A_CTRL, w);
            chk_outs("R9 rand", w);
            rd(A_CTRL, v);  chk("R5 rand", v, ctrl_exp(w));
        end

        wr(A_CTRL, 32'h0000_0026);
        rd(A_CTRL, v);  chk("R7 inactive read", v, 32'h0);
        chk_outs("R7 inactive outs", 32'h0);
        rd(A_STAT, v);  chk("R7 still auth", v[6], 1'b1);

        wr(A_CTRL, 32'h0000_0001);
        rd(A_STAT, v);  chk("R4 auth dropped", v[6], 1'b0);
        rd(A_CTRL, v);  chk("R4 fields cleared", v, 32'h1);
        chk_outs("R4 outs", 32'h1);
        rd(A_AUTH, c1); chk("R10 new challenge", 32'(c1 != c0), 32'h1);

        wr(A_CTRL, 32'h0000_0000);
        rd(A_CTRL, v);  chk("R2 deactivate unauth", v, 32'h0);
        wr(A_CTRL, 32'h0000_0001);
        rd(A_AUTH, v);  chk("R10 third challenge", 32'(v != c1), 32'h1);
        c1 = v;

        wr(A_AUTH, resp_of(c0));
        rd(A_STAT, v);  chk("R8 stale response", v[6], 1'b0);
        wr(A_AUTH, resp_of(c1));
        rd(A_STAT, v);  chk("R8 fresh response", v[6], 1'b1);
        w = 32'h0000_0015;
        wr(A_CTRL, w);
        rd(A_CTRL, v);  chk("R5 after reauth", v, ctrl_exp(w));
        chk_outs("R9 hart0", w);

        finish_run();
    end
endmodule